// File: doc/BRIEF.md
# Quadratic white-balance pixel corrector

This block applies a per-channel second-order colour correction to a raw colour-filter-array stream, before demosaicing. One sample arrives per clock with a valid strobe and frame-start / frame-end markers. At red sites the output is u_R·I² + v_R·I, at blue sites it is u_B·I² + v_B·I, and green sites pass through unchanged. The mosaic layout is preserved: one output sample per input sample, in the same order. All markers travel with their pixel through a fixed four-clock pipeline.

The block locates each site from the line length (a parameter), a column/row counter that restarts at every frame start, and a 2-bit phase input that says which colour sits at the top-left corner. Coefficients are written one at a time into staging registers at any time. They are copied into the working set when the next frame-start pixel is accepted, so a frame is never split across two coefficient sets. Out of reset the block is transparent (u = 0, v = 1.0).

Top module: `wb_quad_corrector`

## Requirements
- R1: A pixel accepted with `pix_valid` high in cycle n appears with `out_valid` high in cycle n+4; `out_valid` is exactly `pix_valid` delayed by four clocks.
- R2: `out_sof` and `out_eof` are the accepted input markers delayed by four clocks, each asserted only together with `out_valid` and on the sample that carried it.
- R3: At a red site the output is floor((u_R·I² + v_R·I)·2^22 / 2^22 + 0.5) computed exactly, i.e. the Q2.22 sum is rounded to nearest with ties upward; coefficients are signed 24-bit with 22 fraction bits.
- R4: At a blue site the output follows the same formula with u_B and v_B.
- R5: At a green site the output equals the input sample.
- R6: Site mapping: the column counts accepted pixels from 0 at the frame-start pixel and wraps after LINE_W, each wrap toggling the row parity; with position p = {row parity, column bit 0}, red is at p == phase and blue at p == ~phase, so phase 0 = R G / G B, 1 = G R / B G, 2 = G B / R G, 3 = B G / G R. The phase is taken from `bayer_phase` on the frame-start pixel and held for the frame.
- R7: A corrected result below 0 outputs 0 and one above 255 outputs 255.
- R8: `coef_we` writes `coef_wdata` to a staging register chosen by `coef_sel` (0 = u_R, 1 = v_R, 2 = u_B, 3 = v_B); staged values take effect from the next accepted frame-start pixel, that pixel included, and writes made inside a frame do not affect its remaining pixels.
- R9: After synchronous reset `out_valid` is low and all coefficients are u = 0, v = 1.0, so every sample passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Input sample valid |
| pix_sof | input | 1 | Input sample is the first of a frame |
| pix_eof | input | 1 | Input sample is the last of a frame |
| pix_data | input | PIX_W | Raw mosaic sample |
| bayer_phase | input | 2 | Colour arrangement, sampled at frame start |
| coef_we | input | 1 | Coefficient staging write strobe |
| coef_sel | input | 2 | Coefficient select: 0 u_R, 1 v_R, 2 u_B, 3 v_B |
| coef_wdata | input | COEF_W | Signed fixed-point coefficient value |
| out_valid | output | 1 | Output sample valid |
| out_sof | output | 1 | Output sample is first of frame |
| out_eof | output | 1 | Output sample is last of frame |
| out_data | output | PIX_W | Corrected mosaic sample |

## Verification
The bench builds the block with 8-bit samples, 24-bit coefficients with 22 fraction bits, and 4-pixel lines, so each 256-sample frame holds every code exactly once and the row parity flips every fourth sample. Every frame is run under all four phases and several coefficient sets, one of them with a rounding tie at every odd input and others that push results past both clamp limits. Because of this, every code lands on red, blue and green sites. A frame with gaps in the valid strobe and a frame with coefficient writes inside it show that the counters and the staging behave correctly.

// File: rtl/wbq_pkg.sv
package wbq_pkg;

  typedef enum logic [1:0] {
    SITE_G = 2'd0,
    SITE_R = 2'd1,
    SITE_B = 2'd2
  } site_e;

  localparam int NUM_COEF = 4;

  // Red sits where the 2x2 position equals the phase, blue at its complement.
  function automatic site_e classify(input logic [1:0] pos, input logic [1:0] phase);
    if (pos == phase)       return SITE_R;
    else if (pos == ~phase) return SITE_B;
    else                    return SITE_G;
  endfunction

endpackage

// File: rtl/wbq_site_tracker.sv
module wbq_site_tracker
  import wbq_pkg::*;
#(
  parameter int LINE_W = 320
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pix_valid,
  input  logic       pix_sof,
  input  logic [1:0] phase_in,
  output site_e      site
);

  localparam int CW = (LINE_W > 2) ? $clog2(LINE_W) : 1;
  localparam logic [CW-1:0] LAST_COL = CW'(LINE_W - 1);

  logic [CW-1:0] col_q;
  logic          row_q;
  logic [1:0]    phase_q;

  logic [CW-1:0] pos_col;
  logic          pos_row;
  logic [1:0]    cur_phase;
  logic          at_last;

  always_comb begin
    pos_col   = pix_sof ? '0 : col_q;
    pos_row   = pix_sof ? 1'b0 : row_q;
    cur_phase = pix_sof ? phase_in : phase_q;
    at_last   = (pos_col == LAST_COL);
    site      = classify({pos_row, pos_col[0]}, cur_phase);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q   <= '0;
      row_q   <= 1'b0;
      phase_q <= 2'd0;
    end else if (pix_valid) begin
      col_q <= at_last ? '0 : pos_col + 1'b1;
      row_q <= at_last ? ~pos_row : pos_row;
      if (pix_sof) phase_q <= phase_in;
    end
  end

endmodule

// File: rtl/wbq_coef_bank.sv
module wbq_coef_bank
  import wbq_pkg::*;
#(
  parameter int COEF_W    = 24,
  parameter int COEF_FRAC = 22
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [1:0]                        wr_sel,
  input  logic [COEF_W-1:0]                 wr_data,
  input  logic                              commit,
  output logic [NUM_COEF-1:0][COEF_W-1:0]   eff,
  output logic [NUM_COEF-1:0][COEF_W-1:0]   act
);

  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << COEF_FRAC;

  logic [NUM_COEF-1:0][COEF_W-1:0] stage_q;
  logic [NUM_COEF-1:0][COEF_W-1:0] act_q;

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
    // odd entries are linear terms and reset to 1.0, even entries to 0
    localparam logic [COEF_W-1:0] RST_VAL = (i % 2 == 1) ? UNITY : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[i] <= RST_VAL;
        act_q[i]   <= RST_VAL;
      end else begin
        if (wr_en && wr_sel == 2'(i)) stage_q[i] <= wr_data;
        if (commit)                   act_q[i]   <= stage_q[i];
      end
    end

    assign eff[i] = commit ? stage_q[i] : act_q[i];
  end

  assign act = act_q;

endmodule

// File: rtl/wbq_poly_pipe.sv
module wbq_poly_pipe
  import wbq_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 24,
  parameter int COEF_FRAC = 22
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic                            in_sof,
  input  logic                            in_eof,
  input  site_e                           in_site,
  input  logic [PIX_W-1:0]                in_pix,
  input  logic [NUM_COEF-1:0][COEF_W-1:0] coef,
  output logic                            out_valid,
  output logic                            out_sof,
  output logic                            out_eof,
  output logic [PIX_W-1:0]                out_pix
);

  localparam int SQ_W  = 2 * PIX_W;
  localparam int PV_W  = COEF_W + PIX_W + 1;
  localparam int PU_W  = COEF_W + SQ_W + 1;
  localparam int SUM_W = PU_W + 1;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (COEF_FRAC - 1);
  localparam logic signed [SUM_W-1:0] MAXV = (SUM_W'(1) << PIX_W) - SUM_W'(1);

  // stage 1: capture and coefficient pick
  logic                     s1_valid, s1_sof, s1_eof;
  site_e                    s1_site;
  logic [PIX_W-1:0]         s1_pix;
  logic signed [COEF_W-1:0] s1_u, s1_v, sel_u, sel_v;
  // stage 2: square and linear product
  logic                     s2_valid, s2_sof, s2_eof;
  site_e                    s2_site;
  logic [PIX_W-1:0]         s2_pix;
  logic [SQ_W-1:0]          s2_sq;
  logic signed [COEF_W-1:0] s2_u;
  logic signed [PV_W-1:0]   s2_vi;
  // stage 3: quadratic product
  logic                     s3_valid, s3_sof, s3_eof;
  site_e                    s3_site;
  logic [PIX_W-1:0]         s3_pix;
  logic signed [PU_W-1:0]   s3_ui2;
  logic signed [PV_W-1:0]   s3_vi;

  always_comb begin
    sel_u = '0;
    sel_v = '0;
    case (in_site)
      SITE_R: begin sel_u = coef[0]; sel_v = coef[1]; end
      SITE_B: begin sel_u = coef[2]; sel_v = coef[3]; end
      default: ;
    endcase
  end

  logic signed [PV_W-1:0] v_ext, p_ext;
  logic signed [PU_W-1:0] u_ext, q_ext;
  logic [SQ_W-1:0]        pix_wide;

  always_comb begin
    pix_wide = {{PIX_W{1'b0}}, s1_pix};
    v_ext    = PV_W'(s1_v);
    p_ext    = PV_W'({1'b0, s1_pix});
    u_ext    = PU_W'(s2_u);
    q_ext    = PU_W'({1'b0, s2_sq});
  end

  logic signed [SUM_W-1:0] sum, scaled;
  logic [PIX_W-1:0]        clamped;

  always_comb begin
    sum    = SUM_W'(s3_ui2) + SUM_W'(s3_vi) + HALF;
    scaled = sum >>> COEF_FRAC;
    if (scaled < 0)         clamped = '0;
    else if (scaled > MAXV) clamped = MAXV[PIX_W-1:0];
    else                    clamped = scaled[PIX_W-1:0];
  end

  // control chain with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0; s1_sof <= 1'b0; s1_eof <= 1'b0;
      s2_valid <= 1'b0; s2_sof <= 1'b0; s2_eof <= 1'b0;
      s3_valid <= 1'b0; s3_sof <= 1'b0; s3_eof <= 1'b0;
      out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0;
      out_pix  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_sof   <= in_valid & in_sof;
      s1_eof   <= in_valid & in_eof;
      s2_valid <= s1_valid; s2_sof <= s1_sof; s2_eof <= s1_eof;
      s3_valid <= s2_valid; s3_sof <= s2_sof; s3_eof <= s2_eof;
      out_valid <= s3_valid; out_sof <= s3_sof; out_eof <= s3_eof;
      out_pix  <= (s3_site == SITE_G) ? s3_pix : clamped;
    end
  end

  // datapath registers, no reset needed
  always_ff @(posedge clk) begin
    s1_site <= in_site;
    s1_pix  <= in_pix;
    s1_u    <= sel_u;
    s1_v    <= sel_v;

    s2_site <= s1_site;
    s2_pix  <= s1_pix;
    s2_u    <= s1_u;
    s2_sq   <= pix_wide * pix_wide;
    s2_vi   <= v_ext * p_ext;

    s3_site <= s2_site;
    s3_pix  <= s2_pix;
    s3_vi   <= s2_vi;
    s3_ui2  <= u_ext * q_ext;
  end

endmodule

// File: rtl/wb_quad_corrector.sv
module wb_quad_corrector
  import wbq_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 24,
  parameter int COEF_FRAC = 22,
  parameter int LINE_W    = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic              pix_eof,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic [1:0]        bayer_phase,
  input  logic              coef_we,
  input  logic [1:0]        coef_sel,
  input  logic [COEF_W-1:0] coef_wdata,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [PIX_W-1:0]  out_data
);

  site_e                           cur_site;
  logic                            commit;
  logic [NUM_COEF-1:0][COEF_W-1:0] eff_coef;
  logic [NUM_COEF-1:0][COEF_W-1:0] act_coef;

  assign commit = pix_valid & pix_sof;

  wbq_site_tracker #(.LINE_W(LINE_W)) u_site (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_sof   (pix_sof),
    .phase_in  (bayer_phase),
    .site      (cur_site)
  );

  wbq_coef_bank #(.COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_coef (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (coef_we),
    .wr_sel  (coef_sel),
    .wr_data (coef_wdata),
    .commit  (commit),
    .eff     (eff_coef),
    .act     (act_coef)
  );

  wbq_poly_pipe #(.PIX_W(PIX_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (pix_valid),
    .in_sof    (pix_sof),
    .in_eof    (pix_eof),
    .in_site   (cur_site),
    .in_pix    (pix_data),
    .coef      (eff_coef),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_pix   (out_data)
  );

endmodule

// File: rtl/wbq_checker.sv
module wbq_checker
  import wbq_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 24
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            pix_valid,
  input logic                            pix_sof,
  input logic                            pix_eof,
  input logic [PIX_W-1:0]                pix_data,
  input site_e                           in_site,
  input logic                            out_valid,
  input logic                            out_sof,
  input logic                            out_eof,
  input logic [PIX_W-1:0]                out_data,
  input logic [NUM_COEF-1:0][COEF_W-1:0] act
);

  logic [2:0] age;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)             age <= 3'd0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  assign warm = (age >= 3'd4);

  assert_latency_valid_R1: assert property (@(posedge clk) disable iff (rst)
    warm |-> out_valid == $past(pix_valid, 4));

  assert_sof_with_valid_R2: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  assert_eof_delay_R2: assert property (@(posedge clk) disable iff (rst)
    warm |-> out_eof == $past(pix_valid && pix_eof, 4));

  assert_zero_input_R3: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(pix_valid && pix_data == '0, 4)) |-> out_data == '0);

  assert_green_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (warm && out_valid && $past(in_site, 4) == SITE_G) |-> out_data == $past(pix_data, 4));

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(pix_valid && pix_sof) |=> $stable(act));

  assert_reset_idle_R9: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

endmodule

bind wb_quad_corrector wbq_checker #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pix_valid (pix_valid),
  .pix_sof   (pix_sof),
  .pix_eof   (pix_eof),
  .pix_data  (pix_data),
  .in_site   (cur_site),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .out_data  (out_data),
  .act       (act_coef)
);

// File: tb/tb_wb_quad_corrector.sv
module tb_wb_quad_corrector;

  localparam int PIX_W = 8;
  localparam int COEF_W = 24;
  localparam int COEF_FRAC = 22;
  localparam int LINE_W = 4;
  localparam int ONE = 1 << COEF_FRAC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_valid = 1'b0, pix_sof = 1'b0, pix_eof = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic [1:0] bayer_phase = 2'd0;
  logic coef_we = 1'b0;
  logic [1:0] coef_sel = 2'd0;
  logic [COEF_W-1:0] coef_wdata = '0;
  logic out_valid, out_sof, out_eof;
  logic [PIX_W-1:0] out_data;

  wb_quad_corrector #(.PIX_W(PIX_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
                      .LINE_W(LINE_W)) dut (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_eof(pix_eof), .pix_data(pix_data), .bayer_phase(bayer_phase),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_wdata(coef_wdata),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_data(out_data)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    data;
    bit    sof;
    bit    eof;
    int    t;
    string tag;
  } exp_t;
  exp_t expq[$];

  // bench coefficient model: index 0 uR, 1 vR, 2 uB, 3 vB
  int stage_c[4] = '{0, ONE, 0, ONE};
  int act_c[4]   = '{0, ONE, 0, ONE};
  int m_phase = 0, m_col = 0, m_row = 0;
  string tag_override = "";

  function automatic int poly(int i, int u, int v);
    longint acc, r;
    acc = longint'(u) * longint'(i * i) + longint'(v) * longint'(i);
    r = (acc + longint'(1 << (COEF_FRAC - 1))) >>> COEF_FRAC;
    if (r < 0) return 0;
    if (r > 255) return 255;
    return int'(r);
  endfunction

  // 0 green, 1 red, 2 blue per R6 table
  function automatic int site_of(int ph, int row, int col);
    int p;
    p = (row % 2) * 2 + (col % 2);
    case (ph)
      0: return (p == 0) ? 1 : (p == 3) ? 2 : 0;
      1: return (p == 1) ? 1 : (p == 2) ? 2 : 0;
      2: return (p == 2) ? 1 : (p == 1) ? 2 : 0;
      default: return (p == 3) ? 1 : (p == 0) ? 2 : 0;
    endcase
  endfunction

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0; coef_we = 1'b0;
    end
  endtask

  task automatic wcoef(input int sel, input int val);
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
    coef_we = 1'b1; coef_sel = 2'(sel); coef_wdata = COEF_W'(val);
    stage_c[sel] = val;
  endtask

  task automatic wset(input int ur, input int vr, input int ub, input int vb);
    wcoef(0, ur); wcoef(1, vr); wcoef(2, ub); wcoef(3, vb);
    idle(1);
  endtask

  task automatic push(input int val, input bit sof, input bit eof, input int ph);
    exp_t e;
    int s;
    @(negedge clk);
    coef_we = 1'b0;
    pix_valid = 1'b1; pix_sof = sof; pix_eof = eof; pix_data = PIX_W'(val);
    if (sof) begin
      bayer_phase = 2'(ph);
      m_phase = ph; m_col = 0; m_row = 0;
      for (int k = 0; k < 4; k++) act_c[k] = stage_c[k];
    end
    s = site_of(m_phase, m_row, m_col);
    e.data = (s == 1) ? poly(val, act_c[0], act_c[1]) :
             (s == 2) ? poly(val, act_c[2], act_c[3]) : val;
    e.tag = (tag_override != "") ? tag_override : (s == 1) ? "R3" : (s == 2) ? "R4" : "R5";
    e.sof = sof; e.eof = eof; e.t = cyc;
    expq.push_back(e);
    if (m_col == LINE_W - 1) begin m_col = 0; m_row = m_row + 1; end
    else m_col = m_col + 1;
  endtask

  // 256-sample frame covering every code once; optional valid gaps; optional
  // mid-frame coefficient writes (R8)
  task automatic frame(input int ph, input int seed, input bit gaps, input bit midwr);
    for (int i = 0; i < 256; i++) begin
      if (gaps && (i % 5 == 3)) idle(1 + i % 3);
      if (midwr && i == 100) begin
        wcoef(0, -ONE); wcoef(1, 0); wcoef(2, -ONE); wcoef(3, 0);
      end
      push((i * 37 + seed) & 255, i == 0, i == 255, ph);
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (expq.size() > 0 && expq[0].t + 4 < cyc) begin
        errors++; checks++;
        $display("FAIL R1 missing output: actual=none expected=%0d at cycle %0d",
                 expq[0].data, expq[0].t + 4);
        void'(expq.pop_front());
      end
      if (out_valid) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected output: actual=%0d expected=none", out_data);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (e.t + 4 != cyc) begin
            errors++;
            $display("FAIL R1 latency: actual=%0d expected=4", cyc - e.t);
          end else if (out_data != PIX_W'(e.data)) begin
            errors++;
            $display("FAIL %s data: actual=%0d expected=%0d", e.tag, out_data, e.data);
          end else if (out_sof != e.sof || out_eof != e.eof) begin
            errors++;
            $display("FAIL R2 markers: actual=%0b%0b expected=%0b%0b",
                     out_sof, out_eof, e.sof, e.eof);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: actual=%0b expected=0", out_valid);
    end
    @(negedge clk) rst = 1'b0;
    idle(3);

    // R9: defaults are transparent, across all phases (R6 irrelevant here)
    tag_override = "R9";
    for (int ph = 0; ph < 4; ph++) frame(ph, ph * 11, 1'b0, 1'b0);
    tag_override = "";
    idle(6);

    // R3/R4/R6: tie rounding at odd inputs on red, small quadratic on blue
    wset(0, ONE / 2, 1024, 3 * ONE / 4);
    for (int ph = 0; ph < 4; ph++) frame(ph, 5 + ph, 1'b0, 1'b0);

    // R7: red forced negative, blue forced above full scale
    wset(-ONE, ONE / 4, 32'h7A0000, ONE);
    for (int ph = 0; ph < 4; ph++) frame(ph, 17 * ph, 1'b0, 1'b0);

    // R3/R4: mixed-sign coefficients
    wset(32'h2000, 7 * ONE / 8, -32'h1000, 5 * ONE / 4);
    for (int ph = 0; ph < 4; ph++) frame(3 - ph, 99 + ph, 1'b0, 1'b0);

    // R6: gaps in the valid strobe must not advance the site counters
    frame(1, 42, 1'b1, 1'b0);
    frame(2, 7, 1'b1, 1'b0);

    // R8: writes inside a frame take effect only at the next frame start
    frame(0, 3, 1'b0, 1'b1);
    frame(3, 8, 1'b0, 1'b0);

    idle(10);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R1 drain: actual=%0d expected=0 pending", expq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule